// File: doc/BRIEF.md
# Dual-Consumer Audio Serial Clock Master

This block is the single clock master for a serial audio link with two consumers: a host processor and an audio codec. Both act as slaves. Two reference oscillators feed the block, one per sample-rate family (nominally near 45 MHz and near 49 MHz). A source select picks one of them through a glitch-free clock switch, and every derived clock counts edges of that reference. The codec receives an oversampling master clock, a bit clock and a left/right frame clock. The host receives its own bit clock and its own frame clock, but no master clock.

A rate code sets the master-clock divider. The bit clock always runs at one quarter of the master clock, which gives 32 bit periods per channel slot and a 256-to-1 master-to-frame ratio. When enabled, the codec clocks start first. The host pair is released only on the frame boundary that follows one full codec frame, so the host joins on a clean left slot. Disabling the block, or changing the rate or the source while it runs, lets the current frame finish and then parks every output low. A source change switches the reference only while all outputs are parked. After a change with the enable still set, the codec-first start sequence runs again.

Top module: `i2s_clock_master`

## Requirements
- R1: While reset is asserted, and while the enable is low after the last frame has ended, all five clock outputs stay low.
- R2: The master clock period equals `2 << (3 - rate)` cycles of the selected reference for rate codes 0 to 3 (16, 8, 4, 2).
- R3: The bit clock period is exactly four master clock periods, and a bit clock rising edge coincides with a master clock falling edge.
- R4: A frame clock changes only in the sample where its bit clock falls. Each half frame holds 32 bit clock rising edges. The frame clock is low (left slot) for the first half and high (right slot) for the second.
- R5: After start, the host bit and frame clocks stay low through exactly one codec frame. They are released at the next codec frame clock falling edge, so the first host bit clock rise comes two master periods after that edge, with the frame clock low.
- R6: While the host pair runs, the host bit and frame clocks equal the codec bit and frame clocks in every cycle.
- R7: A stop takes effect only at a frame boundary: in the last active sample the master, bit and frame clocks are all high, and in the next sample they are all low.
- R8: A rate code change while enabled finishes the current frame, stops all clocks, then restarts at the new rate with the codec-first sequence of R5.
- R9: Only one reference drives the derived clocks at any time. After a source change, periods are measured in cycles of the newly selected reference.
- R10: A source select change while enabled behaves like R8: stop at the frame boundary, switch the reference while all outputs are idle, then restart codec first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, held while both references run |
| ref_clk_a | input | 1 | Reference oscillator for the 44.1 kHz family (source code 0) |
| ref_clk_b | input | 1 | Reference oscillator for the 48 kHz family (source code 1) |
| clk_en | input | 1 | Enable for all generated clocks, asynchronous to both references |
| ref_sel | input | 1 | Reference source select: 0 picks ref_clk_a, 1 picks ref_clk_b |
| rate_sel | input | 2 | Rate code, 0 slowest to 3 fastest (master divider 16, 8, 4, 2) |
| codec_mclk | output | 1 | Master clock to the codec (256 times the frame rate) |
| codec_bclk | output | 1 | Bit clock to the codec |
| codec_lrclk | output | 1 | Frame clock to the codec, low for left, high for right |
| host_bclk | output | 1 | Bit clock to the host |
| host_lrclk | output | 1 | Frame clock to the host |

## Verification
The case that needs care is a rate or source change that arrives while the host pair runs. The frame-boundary wrap that would normally continue the frame must instead end it, in the same cycle that the stop decision is taken. The bench provokes this by changing the rate code, and later the source select, with the enable held high. It then looks for a long low run on the host pair whose preceding sample shows the host bit and frame clocks both high. After that it requires a fresh codec lead-in at the new period, measured in ticks of the new reference, before the host bit clock rises again two master periods after a codec frame clock fall.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

    // Number of selectable master-clock dividers; divider = 2 << (NUM_RATES-1-code)
    localparam int NUM_RATES          = 4;
    localparam int RATE_W             = $clog2(NUM_RATES);
    // Master clocks per bit clock, as a power of two
    localparam int MCLK_PER_BCLK_LOG2 = 2;
    // Bit clocks per channel slot, as a power of two
    localparam int SLOT_BITS_LOG2     = 5;
    // Largest divider exponent
    localparam int MAX_DIV_LOG2       = NUM_RATES;
    // Frame counter covers two slots at the slowest rate
    localparam int FRAME_LOG2_OFS     = MCLK_PER_BCLK_LOG2 + SLOT_BITS_LOG2 + 1;
    localparam int PH_W               = MAX_DIV_LOG2 + FRAME_LOG2_OFS;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SWAP,
        SEQ_CODEC,
        SEQ_HOST
    } seq_state_t;

    // Control request after synchronisation
    typedef struct packed {
        logic  en;
        logic  sel;
        rate_t rate;
    } clk_req_t;

    // One set of derived clock levels
    typedef struct packed {
        logic mclk;
        logic bclk;
        logic lrclk;
    } clk_set_t;

    // Serial pair handed to a slave
    typedef struct packed {
        logic bclk;
        logic lrclk;
    } serial_pair_t;

    function automatic int div_log2(rate_t code);
        return NUM_RATES - int'(code);
    endfunction

    function automatic phase_t frame_last(rate_t code);
        return phase_t'((1 << (div_log2(code) + FRAME_LOG2_OFS)) - 1);
    endfunction

    function automatic clk_set_t tap_phase(phase_t ph, rate_t code);
        clk_set_t s;
        int k;
        k       = div_log2(code);
        s.mclk  = ph[k-1];
        s.bclk  = ph[k+MCLK_PER_BCLK_LOG2-1];
        s.lrclk = ph[k+MCLK_PER_BCLK_LOG2+SLOT_BITS_LOG2];
        return s;
    endfunction

endpackage

// File: rtl/i2s_refclk_mux.sv
module i2s_refclk_mux (
    input  logic rst,
    input  logic ref_a,
    input  logic ref_b,
    input  logic pick_b,
    output logic gclk
);

    logic arm_a_q, arm_b_q;
    logic on_a_q, on_b_q;

    // Side A: arm on rising edge, open on falling edge (clock low)
    always_ff @(posedge ref_a) begin
        if (rst) arm_a_q <= 1'b1;
        else     arm_a_q <= !pick_b && !on_b_q;
    end

    always_ff @(negedge ref_a) begin
        if (rst) on_a_q <= 1'b1;
        else     on_a_q <= arm_a_q;
    end

    // Side B: same structure, inactive out of reset
    always_ff @(posedge ref_b) begin
        if (rst) arm_b_q <= 1'b0;
        else     arm_b_q <= pick_b && !on_a_q;
    end

    always_ff @(negedge ref_b) begin
        if (rst) on_b_q <= 1'b0;
        else     on_b_q <= arm_b_q;
    end

    assign gclk = (ref_a && on_a_q) || (ref_b && on_b_q);

    // R9: the two gates are never open together
    a_r9_single_source_a: assert property (@(posedge ref_a) disable iff (rst)
        $onehot0({on_a_q, on_b_q}));
    a_r9_single_source_b: assert property (@(posedge ref_b) disable iff (rst)
        $onehot0({on_a_q, on_b_q}));

endmodule

// File: rtl/i2s_ctrl_sync.sv
module i2s_ctrl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2s_seq.sv
module i2s_seq
    import i2s_clkgen_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_req_t want,
    output phase_t   phase,
    output rate_t    rate_act,
    output logic     sel_act,
    output logic     codec_run,
    output logic     host_run
);

    localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

    seq_state_t          state;
    clk_req_t            samp_q, req_q;
    logic                stop_pend;
    logic [SETTLE_W-1:0] settle;
    logic                at_last, change_req, stop_now;

    assign at_last    = (phase == frame_last(rate_act));
    assign change_req = !req_q.en || (req_q.sel != sel_act) || (req_q.rate != rate_act);
    assign stop_now   = stop_pend || change_req;
    assign codec_run  = (state == SEQ_CODEC) || (state == SEQ_HOST);
    assign host_run   = (state == SEQ_HOST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            phase     <= '0;
            rate_act  <= '0;
            sel_act   <= 1'b0;
            stop_pend <= 1'b0;
            settle    <= '0;
            samp_q    <= '0;
            req_q     <= '0;
        end else begin
            // Accept a control word only once it has held for two samples
            samp_q <= want;
            if (samp_q == want) req_q <= want;

            case (state)
                SEQ_IDLE: begin
                    phase     <= '0;
                    stop_pend <= 1'b0;
                    if (req_q.sel != sel_act) begin
                        sel_act <= req_q.sel;
                        settle  <= '0;
                        state   <= SEQ_SWAP;
                    end else if (req_q.en) begin
                        rate_act <= req_q.rate;
                        state    <= SEQ_CODEC;
                    end
                end
                SEQ_SWAP: begin
                    if (settle == SETTLE_W'(SETTLE_CYCLES - 1)) state <= SEQ_IDLE;
                    else settle <= settle + 1'b1;
                end
                default: begin
                    if (at_last) begin
                        phase     <= '0;
                        stop_pend <= 1'b0;
                        state     <= stop_now ? SEQ_IDLE : SEQ_HOST;
                    end else begin
                        phase     <= phase_t'(phase + 1'b1);
                        stop_pend <= stop_now;
                    end
                end
            endcase
        end
    end

    // R5: host release only from the codec lead-in, at the frame start
    a_r5_host_after_codec_frame: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HOST && $past(state) != SEQ_HOST)
            |-> ($past(state) == SEQ_CODEC && phase == '0));

    // R7: running ends only from the last phase of a frame
    a_r7_stop_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && ($past(state) == SEQ_CODEC || $past(state) == SEQ_HOST))
            |-> ($past(phase) == frame_last($past(rate_act))));

    // R2: the frame counter never leaves its window
    a_r2_phase_in_frame: assert property (@(posedge clk) disable iff (rst)
        phase <= frame_last(rate_act));

    // R9/R10: the source only changes while idle
    a_r10_source_change_idle: assert property (@(posedge clk) disable iff (rst)
        (sel_act != $past(sel_act)) |-> ($past(state) == SEQ_IDLE));

endmodule

// File: rtl/i2s_clk_outs.sv
module i2s_clk_outs
    import i2s_clkgen_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  phase_t       phase,
    input  rate_t        rate,
    input  logic         codec_run,
    input  logic         host_run,
    output clk_set_t     codec_q,
    output serial_pair_t host_q
);

    clk_set_t tapped;

    assign tapped = tap_phase(phase, rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            codec_q <= '0;
            host_q  <= '0;
        end else begin
            codec_q <= codec_run ? tapped : '0;
            host_q  <= host_run ? '{bclk: tapped.bclk, lrclk: tapped.lrclk} : '0;
        end
    end

    // R4: frame clock edges only where the bit clock falls
    a_r4_lr_on_bclk_fall: assert property (@(posedge clk) disable iff (rst)
        ($rose(codec_q.lrclk) || $fell(codec_q.lrclk)) |-> $fell(codec_q.bclk));

    // R3: bit clock rises together with a master clock fall
    a_r3_bclk_on_mclk_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(codec_q.bclk) |-> $fell(codec_q.mclk));

    // R6: a running host pair mirrors the codec pair
    a_r6_host_tracks_codec: assert property (@(posedge clk) disable iff (rst)
        (host_q.bclk || host_q.lrclk)
            |-> (host_q.bclk == codec_q.bclk && host_q.lrclk == codec_q.lrclk));

endmodule

// File: rtl/i2s_clock_master.sv
module i2s_clock_master
    import i2s_clkgen_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic              rst,
    input  logic              ref_clk_a,
    input  logic              ref_clk_b,
    input  logic              clk_en,
    input  logic              ref_sel,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              codec_mclk,
    output logic              codec_bclk,
    output logic              codec_lrclk,
    output logic              host_bclk,
    output logic              host_lrclk
);

    localparam int REQ_W = $bits(clk_req_t);

    logic         gclk;
    logic         sel_act;
    clk_req_t     want_raw, want_sync;
    phase_t       phase;
    rate_t        rate_act;
    logic         codec_run, host_run;
    clk_set_t     codec_q;
    serial_pair_t host_q;

    assign want_raw = '{en: clk_en, sel: ref_sel, rate: rate_sel};

    i2s_refclk_mux u_mux (
        .rst    (rst),
        .ref_a  (ref_clk_a),
        .ref_b  (ref_clk_b),
        .pick_b (sel_act),
        .gclk   (gclk)
    );

    i2s_ctrl_sync #(
        .W      (REQ_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (gclk),
        .rst (rst),
        .d   (want_raw),
        .q   (want_sync)
    );

    i2s_seq #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_seq (
        .clk       (gclk),
        .rst       (rst),
        .want      (want_sync),
        .phase     (phase),
        .rate_act  (rate_act),
        .sel_act   (sel_act),
        .codec_run (codec_run),
        .host_run  (host_run)
    );

    i2s_clk_outs u_outs (
        .clk       (gclk),
        .rst       (rst),
        .phase     (phase),
        .rate      (rate_act),
        .codec_run (codec_run),
        .host_run  (host_run),
        .codec_q   (codec_q),
        .host_q    (host_q)
    );

    assign codec_mclk  = codec_q.mclk;
    assign codec_bclk  = codec_q.bclk;
    assign codec_lrclk = codec_q.lrclk;
    assign host_bclk   = host_q.bclk;
    assign host_lrclk  = host_q.lrclk;

endmodule

// File: tb/tb_i2s_clock_master.sv
`timescale 1ns/1ps
module tb_i2s_clock_master;

    logic       rst = 1'b1;
    logic       ref_clk_a = 1'b0;
    logic       ref_clk_b = 1'b0;
    logic       clk_en = 1'b0;
    logic       ref_sel = 1'b0;
    logic [1:0] rate_sel = 2'd3;
    logic       codec_mclk, codec_bclk, codec_lrclk, host_bclk, host_lrclk;

    int  vectors = 0;
    int  fails   = 0;
    bit  cur_sel = 1'b0;
    bit  done    = 1'b0;

    always #4 ref_clk_a = ~ref_clk_a;   // 125 MHz
    always #5 ref_clk_b = ~ref_clk_b;   // second reference

    i2s_clock_master dut (
        .rst         (rst),
        .ref_clk_a   (ref_clk_a),
        .ref_clk_b   (ref_clk_b),
        .clk_en      (clk_en),
        .ref_sel     (ref_sel),
        .rate_sel    (rate_sel),
        .codec_mclk  (codec_mclk),
        .codec_bclk  (codec_bclk),
        .codec_lrclk (codec_lrclk),
        .host_bclk   (host_bclk),
        .host_lrclk  (host_lrclk)
    );

    function automatic int mdiv(int r);
        return 2 << (3 - r);
    endfunction

    function automatic bit all_low();
        return !(codec_mclk || codec_bclk || codec_lrclk || host_bclk || host_lrclk);
    endfunction

    task automatic tick();
        if (cur_sel) @(negedge ref_clk_b);
        else         @(negedge ref_clk_a);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Start-up, lead-in, release and one running frame
    task automatic run_session(int rate, bit fresh);
        int md, frame, n, t, lr_falls, since_fall, mlast, mper, blast, bper;
        int cnt, mism, badedge, badseg, segs;
        bit pm, pb, pl, early;
        md = mdiv(rate); frame = 256 * md;
        lr_falls = 0; since_fall = 0; mlast = -1; mper = -1; blast = -1; bper = -1;
        early = 1'b0; n = 0;
        while (!codec_mclk && n < 20000) begin
            tick(); n++;
            if (host_bclk || host_lrclk) early = 1'b1;
        end
        check(n < 20000, "R2 master clock starts", n, 20000);
        pm = codec_mclk; pb = codec_bclk; pl = codec_lrclk; t = 0;
        while (!host_bclk && t < 4 * frame + 200) begin
            tick(); t++;
            if (codec_mclk && !pm) begin
                if (mlast >= 0 && mper < 0) mper = t - mlast;
                mlast = t;
            end
            if (codec_bclk && !pb) begin
                if (blast >= 0 && bper < 0) bper = t - blast;
                blast = t;
            end
            if (!codec_lrclk && pl) begin lr_falls++; since_fall = 0; end
            else since_fall++;
            if (host_lrclk) early = 1'b1;
            pm = codec_mclk; pb = codec_bclk; pl = codec_lrclk;
        end
        check(mper == md, "R2 master period", mper, md);
        check(bper == 4 * md, "R3 bit clock period", bper, 4 * md);
        check(!early, "R5 host held during lead-in", early, 0);
        check(since_fall == 2 * md, "R5 host release offset", since_fall, 2 * md);
        if (fresh) check(lr_falls == 1, "R5 one codec frame before host", lr_falls, 1);
        check(codec_lrclk == 1'b0, "R4 left slot first", codec_lrclk, 0);
        cnt = 1; mism = 0; badedge = 0; badseg = 0; segs = 0;
        pb = codec_bclk; pl = codec_lrclk;
        for (int i = 0; i < frame; i++) begin
            tick();
            if (host_bclk != codec_bclk || host_lrclk != codec_lrclk) mism++;
            if (codec_bclk && !pb) cnt++;
            if (codec_lrclk != pl) begin
                if (!(pb && !codec_bclk)) badedge++;
                if (cnt != 32) badseg++;
                segs++; cnt = 0;
            end
            pb = codec_bclk; pl = codec_lrclk;
        end
        check(mism == 0, "R6 host equals codec", mism, 0);
        check(badedge == 0, "R4 frame edge on bit fall", badedge, 0);
        check(badseg == 0 && segs == 2, "R4 32 bits per slot", segs, 2);
    endtask

    // Wait for the host pair to park; the sample before must be frame end
    task automatic await_host_stop(int md_old, string tag);
        int run, n;
        bit lb, ll, lm;
        run = 0; n = 0; lb = 0; ll = 0; lm = 0;
        while (run < 4 * md_old && n < 30000) begin
            tick(); n++;
            if (host_bclk || host_lrclk) begin
                run = 0; lb = host_bclk; ll = host_lrclk; lm = codec_mclk;
            end else run++;
        end
        check(n < 30000, {tag, " host stops"}, n, 30000);
        check(lb && ll && lm, {tag, " stop at frame end"}, {lm, lb, ll}, 7);
    endtask

    task automatic quiet_check(int len);
        int bad;
        bad = 0;
        for (int i = 0; i < len; i++) begin
            tick();
            if (!all_low()) bad++;
        end
        check(bad == 0, "R1 outputs idle while disabled", bad, 0);
    endtask

    // Fresh start, change on the fly, then disable
    task automatic change_case(int r1, bit s1, int r2, bit s2);
        string tag;
        rate_sel = 2'(r1); ref_sel = s1; cur_sel = s1; clk_en = 1'b1;
        run_session(r1, 1'b1);
        tag = (s1 != s2) ? "R10" : "R8";
        rate_sel = 2'(r2); ref_sel = s2;
        await_host_stop(mdiv(r1), tag);
        cur_sel = s2;
        run_session(r2, 1'b0);
        clk_en = 1'b0;
        await_host_stop(mdiv(r2), "R7");
        quiet_check(4 * mdiv(r2) + 64);
    endtask

    initial begin
        int seed, r1, r2;
        bit s1, s2;
        seed = $urandom(32'd2024);
        // Reset state
        for (int i = 0; i < 20; i++) begin
            tick();
            check(all_low(), "R1 outputs low in reset", 1, 0);
            if (i == 19) rst = 1'b0;
        end
        quiet_check(60);

        // Fastest rate on reference A
        rate_sel = 2'd3; clk_en = 1'b1;
        run_session(3, 1'b1);
        clk_en = 1'b0;
        await_host_stop(mdiv(3), "R7");
        quiet_check(256 * mdiv(3) + 32);

        // Slowest rate on reference A
        rate_sel = 2'd0; clk_en = 1'b1;
        run_session(0, 1'b1);
        clk_en = 1'b0;
        await_host_stop(mdiv(0), "R7");
        quiet_check(4 * mdiv(0) + 64);

        // Directed: source switch while stopped (R9), then rate change on the fly (R8)
        ref_sel = 1'b1; cur_sel = 1'b1;
        quiet_check(40);
        change_case(2, 1'b1, 1, 1'b1);
        // Directed: source change while running (R10)
        change_case(1, 1'b1, 1, 1'b0);

        // Random mixes
        for (int it = 0; it < 4; it++) begin
            r1 = $urandom_range(1, 3); s1 = 1'($urandom_range(0, 1));
            r2 = $urandom_range(1, 3); s2 = 1'($urandom_range(0, 1));
            if (r1 == r2 && s1 == s2) r2 = (r1 == 3) ? 1 : r1 + 1;
            change_case(r1, s1, r2, s2);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            vectors++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule